// File: doc/BRIEF.md
# Multi-File Rename Capacity Tracker

This block keeps the occupancy accounts for a set of physical register files that feed register renaming. Every architectural register is assigned, through a small configuration table, to an owning register file and a cost, which is the number of mappings one write to that register consumes. The block holds one used-mapping counter per file and a configured capacity per file. File 0 is a catch-all file: every write is charged to it, in addition to the owning file when that owner is another file. A capacity of zero marks a file as unbounded.

A dispatch stage asks the block, in the same cycle, whether a group of up to four written registers fits. The answer is a shortage mask with one bit per register file, so that the stage can tell which file is short rather than just that something is. When a write is committed to the rename map, the stage raises an allocate request. When the mapping is released it raises a free request. Each of these requests changes the counters only while its matching enable input is high. A release that would take a counter below zero clamps it at zero and sets a sticky error flag.

Top module: `rename_tracker`

## Requirements
- R1: After reset, every used counter reads 0, the error flag is 0, every file is unbounded, and every register is owned by file 0 with a cost of 1.
- R2: An allocate request with allocate enable high adds the cost of the register to the counter of its owning file. When the owner is not file 0, it also adds the same cost to the counter of file 0. The counters read the new value after the next rising clock edge.
- R3: An allocate request with allocate enable low leaves every counter unchanged.
- R4: A free request with free enable high subtracts the same amounts that an allocate of that register would add. A free request with free enable low leaves every counter unchanged.
- R5: A free that would take a counter below zero leaves that counter at 0 and sets the error flag. The error flag then stays at 1 until reset.
- R6: The shortage mask is combinational from the query inputs. Bit i (file i) is 1 exactly when the capacity of file i is non-zero and the used count of file i plus the total charge of the query to file i is greater than that capacity. A sum equal to the capacity is not a shortage.
- R7: A file whose capacity is 0 never sets its shortage bit, whatever the query asks for.
- R8: A query charges each slot whose valid bit is 1 and ignores each slot whose valid bit is 0. A register that appears in several slots is charged once per slot.
- R9: An allocate and a free in the same cycle both take effect: each counter moves by the allocated amount minus the freed amount.
- R10: A map write sets the owner file and the cost of one register ID. A capacity write sets the capacity of one file. Each write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_map_we | input | 1 | Write the owner file and cost of one register |
| cfg_map_reg | input | 4 | Register ID for the map write |
| cfg_map_file | input | 2 | Owner file index to store |
| cfg_map_cost | input | 3 | Cost to store |
| cfg_cap_we | input | 1 | Write the capacity of one file |
| cfg_cap_file | input | 2 | File index for the capacity write |
| cfg_cap_val | input | 8 | Capacity (0 = unbounded) |
| qry_valid | input | 4 | Per-slot valid bits of the query |
| qry_regs | input | 16 | Query register IDs, slot k at bits [4k+3:4k] |
| qry_short | output | 4 | Shortage mask, bit i for file i |
| alloc_req | input | 1 | Allocate mappings for one write |
| alloc_en | input | 1 | Allow the allocate to change counters |
| alloc_reg | input | 4 | Register ID being allocated |
| free_req | input | 1 | Release mappings for one write |
| free_en | input | 1 | Allow the free to change counters |
| free_reg | input | 4 | Register ID being released |
| used_cnt | output | 32 | Used counters, file i at bits [8i+7:8i] |
| free_err | output | 1 | Sticky underflow flag |

## Verification
Both an allocate and a free can arrive in the same cycle, and the same counter may get both an increment and a decrement. To provoke this, the bench allocates a register in file 1 while it frees a register of higher cost in the same file. It then checks that the counters of file 1 and file 0 show the net change, not only one of the two updates. A separate case frees a register whose file is already at zero, while file 0 still holds a balance. That case checks that only the empty file clamps, that file 0 still decrements normally, and that the error flag stays set in later cycles.

// File: rtl/rt_pkg.sv
package rt_pkg;
    parameter int RT_FILES  = 4;
    parameter int RT_REGS   = 16;
    parameter int RT_PORTS  = 4;
    parameter int RT_CNT_W  = 8;
    parameter int RT_COST_W = 3;

    localparam int RT_FID_W = $clog2(RT_FILES);
    localparam int RT_RID_W = $clog2(RT_REGS);
    localparam int RT_REQ_W = RT_COST_W + $clog2(RT_PORTS) + 1;
    localparam int RT_CMP_W = RT_CNT_W + RT_REQ_W;

    typedef logic [RT_FID_W-1:0]  fid_t;
    typedef logic [RT_RID_W-1:0]  rid_t;
    typedef logic [RT_COST_W-1:0] cost_t;
    typedef logic [RT_CNT_W-1:0]  cnt_t;
    typedef logic [RT_REQ_W-1:0]  req_t;

    typedef struct packed {
        fid_t  owner;
        cost_t cost;
    } map_entry_t;

    // Amount a write to a register with this entry charges to file f.
    function automatic cost_t charge_for(map_entry_t e, fid_t f);
        if (f == '0 || e.owner == f) return e.cost;
        return '0;
    endfunction
endpackage

// File: rtl/rt_cfg.sv
module rt_cfg
    import rt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       map_we,
    input  rid_t       map_reg,
    input  fid_t       map_file,
    input  cost_t      map_cost,
    input  logic       cap_we,
    input  fid_t       cap_file,
    input  cnt_t       cap_val,
    output map_entry_t map_tab [RT_REGS],
    output cnt_t       cap_tab [RT_FILES]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < RT_REGS; r++) begin
                map_tab[r].owner <= '0;
                map_tab[r].cost  <= cost_t'(1);
            end
        end else if (map_we) begin
            map_tab[map_reg].owner <= map_file;
            map_tab[map_reg].cost  <= map_cost;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < RT_FILES; f++) cap_tab[f] <= '0;
        end else if (cap_we) begin
            cap_tab[cap_file] <= cap_val;
        end
    end
endmodule

// File: rtl/rt_avail.sv
module rt_avail
    import rt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  map_entry_t              map_tab [RT_REGS],
    input  cnt_t                    cap_tab [RT_FILES],
    input  cnt_t                    used    [RT_FILES],
    input  logic [RT_PORTS-1:0]     qry_valid,
    input  logic [RT_PORTS*RT_RID_W-1:0] qry_regs,
    output logic [RT_FILES-1:0]     short_mask
);
    for (genvar f = 0; f < RT_FILES; f++) begin : g_file
        req_t                req_sum;
        logic [RT_CMP_W-1:0] need;

        always_comb begin
            req_sum = '0;
            for (int k = 0; k < RT_PORTS; k++) begin
                if (qry_valid[k]) begin
                    req_sum = req_sum + req_t'(charge_for(
                        map_tab[qry_regs[k*RT_RID_W +: RT_RID_W]], fid_t'(f)));
                end
            end
            need = RT_CMP_W'(used[f]) + RT_CMP_W'(req_sum);
            short_mask[f] = (cap_tab[f] != '0) && (need > RT_CMP_W'(cap_tab[f]));
        end

        assert_unbounded_never_short_R7: assert property (
            @(posedge clk) disable iff (rst)
            (cap_tab[f] == '0) |-> !short_mask[f]);

        assert_empty_query_clear_R8: assert property (
            @(posedge clk) disable iff (rst)
            (qry_valid == '0 && used[f] <= cap_tab[f]) |-> !short_mask[f]);
    end
endmodule

// File: rtl/rt_counter.sv
module rt_counter
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cost_t inc_amt,
    input  cost_t dec_amt,
    output cnt_t  cnt,
    output logic  uflow
);
    logic [RT_CNT_W:0] grown;

    always_comb begin
        grown = {1'b0, cnt} + (RT_CNT_W+1)'(inc_amt);
        uflow = grown < (RT_CNT_W+1)'(dec_amt);
    end

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (uflow) cnt <= '0;
        else            cnt <= cnt_t'(grown - (RT_CNT_W+1)'(dec_amt));
    end

    assert_hold_no_delta_R4: assert property (
        @(posedge clk) disable iff (rst)
        (inc_amt == '0 && dec_amt == '0) |=> $stable(cnt));

    assert_clamp_at_zero_R5: assert property (
        @(posedge clk) disable iff (rst)
        (inc_amt == '0 && dec_amt > cost_t'(0) && cnt < cnt_t'(dec_amt)) |=> (cnt == '0));
endmodule

// File: rtl/rename_tracker.sv
module rename_tracker
    import rt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_map_we,
    input  logic [RT_RID_W-1:0]           cfg_map_reg,
    input  logic [RT_FID_W-1:0]           cfg_map_file,
    input  logic [RT_COST_W-1:0]          cfg_map_cost,
    input  logic                          cfg_cap_we,
    input  logic [RT_FID_W-1:0]           cfg_cap_file,
    input  logic [RT_CNT_W-1:0]           cfg_cap_val,
    input  logic [RT_PORTS-1:0]           qry_valid,
    input  logic [RT_PORTS*RT_RID_W-1:0]  qry_regs,
    output logic [RT_FILES-1:0]           qry_short,
    input  logic                          alloc_req,
    input  logic                          alloc_en,
    input  logic [RT_RID_W-1:0]           alloc_reg,
    input  logic                          free_req,
    input  logic                          free_en,
    input  logic [RT_RID_W-1:0]           free_reg,
    output logic [RT_FILES*RT_CNT_W-1:0]  used_cnt,
    output logic                          free_err
);
    map_entry_t          map_tab [RT_REGS];
    cnt_t                cap_tab [RT_FILES];
    cnt_t                used    [RT_FILES];
    logic [RT_FILES-1:0] uflow;
    logic                do_alloc, do_free;

    assign do_alloc = alloc_req && alloc_en;
    assign do_free  = free_req && free_en;

    rt_cfg u_cfg (
        .clk(clk), .rst(rst),
        .map_we(cfg_map_we), .map_reg(cfg_map_reg),
        .map_file(cfg_map_file), .map_cost(cfg_map_cost),
        .cap_we(cfg_cap_we), .cap_file(cfg_cap_file), .cap_val(cfg_cap_val),
        .map_tab(map_tab), .cap_tab(cap_tab)
    );

    rt_avail u_avail (
        .clk(clk), .rst(rst),
        .map_tab(map_tab), .cap_tab(cap_tab), .used(used),
        .qry_valid(qry_valid), .qry_regs(qry_regs),
        .short_mask(qry_short)
    );

    for (genvar f = 0; f < RT_FILES; f++) begin : g_cnt
        cost_t inc_amt, dec_amt;
        assign inc_amt = do_alloc ? charge_for(map_tab[alloc_reg], fid_t'(f)) : '0;
        assign dec_amt = do_free  ? charge_for(map_tab[free_reg],  fid_t'(f)) : '0;

        rt_counter u_counter (
            .clk(clk), .rst(rst),
            .inc_amt(inc_amt), .dec_amt(dec_amt),
            .cnt(used[f]), .uflow(uflow[f])
        );
        assign used_cnt[f*RT_CNT_W +: RT_CNT_W] = used[f];
    end

    always_ff @(posedge clk) begin
        if (rst)           free_err <= 1'b0;
        else if (|uflow)   free_err <= 1'b1;
    end

    assert_err_sticky_R5: assert property (
        @(posedge clk) disable iff (rst)
        free_err |=> free_err);

    assert_gated_ops_hold_R3: assert property (
        @(posedge clk) disable iff (rst)
        (!alloc_en && !(free_req && free_en)) |=> $stable(used_cnt));

    assert_file0_grows_R2: assert property (
        @(posedge clk) disable iff (rst)
        (alloc_req && alloc_en && !free_req && !$isunknown(alloc_reg))
        |=> (used_cnt[RT_CNT_W-1:0] >= $past(used_cnt[RT_CNT_W-1:0])));
endmodule

// File: tb/rename_tracker_tb.sv
module rename_tracker_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_map_we;
    logic [3:0]  cfg_map_reg;
    logic [1:0]  cfg_map_file;
    logic [2:0]  cfg_map_cost;
    logic        cfg_cap_we;
    logic [1:0]  cfg_cap_file;
    logic [7:0]  cfg_cap_val;
    logic [3:0]  qry_valid;
    logic [15:0] qry_regs;
    logic [3:0]  qry_short;
    logic        alloc_req, alloc_en, free_req, free_en;
    logic [3:0]  alloc_reg, free_reg;
    logic [31:0] used_cnt;
    logic        free_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rename_tracker u_dut (
        .clk(clk), .rst(rst),
        .cfg_map_we(cfg_map_we), .cfg_map_reg(cfg_map_reg),
        .cfg_map_file(cfg_map_file), .cfg_map_cost(cfg_map_cost),
        .cfg_cap_we(cfg_cap_we), .cfg_cap_file(cfg_cap_file), .cfg_cap_val(cfg_cap_val),
        .qry_valid(qry_valid), .qry_regs(qry_regs), .qry_short(qry_short),
        .alloc_req(alloc_req), .alloc_en(alloc_en), .alloc_reg(alloc_reg),
        .free_req(free_req), .free_en(free_en), .free_reg(free_reg),
        .used_cnt(used_cnt), .free_err(free_err)
    );

    // Query vectors: {valid[23:20], slot regs [19:4] (slot k at 4k), mask[3:0]}
    localparam logic [23:0] VEC [8] = '{
        24'h1_0001_0,  // fits
        24'h3_0012_2,  // file 1 short
        24'h7_0333_4,  // file 2 short
        24'hF_4444_1,  // file 3 unbounded, file 0 short
        24'hF_3322_2,  // file 0 exactly full, file 1 short
        24'h0_2222_0,  // no valid slot
        24'h3_0011_0,  // file 1 reaches capacity exactly
        24'h3_0033_0   // file 2 reaches capacity exactly
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int used_of(int f);
        return int'(used_cnt[f*8 +: 8]);
    endfunction

    task automatic chk_used(string tag, int e0, int e1, int e2, int e3);
        chk({tag, " file0"}, used_of(0), e0);
        chk({tag, " file1"}, used_of(1), e1);
        chk({tag, " file2"}, used_of(2), e2);
        chk({tag, " file3"}, used_of(3), e3);
    endtask

    task automatic idle_inputs();
        cfg_map_we = 0; cfg_map_reg = 0; cfg_map_file = 0; cfg_map_cost = 0;
        cfg_cap_we = 0; cfg_cap_file = 0; cfg_cap_val = 0;
        qry_valid = 0; qry_regs = 0;
        alloc_req = 0; alloc_en = 0; alloc_reg = 0;
        free_req = 0; free_en = 0; free_reg = 0;
    endtask

    task automatic set_map(int r, int f, int c);
        @(negedge clk);
        cfg_map_we = 1; cfg_map_reg = 4'(r); cfg_map_file = 2'(f); cfg_map_cost = 3'(c);
        @(negedge clk);
        cfg_map_we = 0;
    endtask

    task automatic set_cap(int f, int v);
        @(negedge clk);
        cfg_cap_we = 1; cfg_cap_file = 2'(f); cfg_cap_val = 8'(v);
        @(negedge clk);
        cfg_cap_we = 0;
    endtask

    // One cycle with optional allocate and free; returns at the next falling edge.
    task automatic op(bit areq, bit aen, int areg, bit freq, bit fen, int freg);
        @(negedge clk);
        alloc_req = areq; alloc_en = aen; alloc_reg = 4'(areg);
        free_req = freq; free_en = fen; free_reg = 4'(freg);
        @(negedge clk);
        alloc_req = 0; alloc_en = 0; free_req = 0; free_en = 0;
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        chk_used("R1 reset", 0, 0, 0, 0);
        chk("R1 err after reset", int'(free_err), 0);
        qry_valid = 4'hF; qry_regs = 16'h0000;
        #2 chk("R1 unbounded after reset mask", int'(qry_short), 0);
        qry_valid = 0;

        // R10: configuration
        set_cap(0, 10); set_cap(1, 4); set_cap(2, 3); set_cap(3, 0);
        set_map(1, 1, 1); set_map(2, 1, 2); set_map(3, 2, 1); set_map(4, 3, 2);

        // R2: allocate r2 (file 1, cost 2)
        op(1, 1, 2, 0, 0, 0);
        chk_used("R2 alloc r2", 2, 2, 0, 0);
        // R3: allocate without enable
        op(1, 0, 2, 0, 0, 0);
        chk_used("R3 alloc no enable", 2, 2, 0, 0);
        // R2: owner file 0 charged once
        op(1, 1, 5, 0, 0, 0);
        chk_used("R2 alloc owner0", 3, 2, 0, 0);
        op(1, 1, 3, 0, 0, 0);
        chk_used("R10 R2 alloc r3", 4, 2, 1, 0);

        // R6 R7 R8: query vectors
        foreach (VEC[i]) begin
            @(negedge clk);
            qry_valid = VEC[i][23:20];
            qry_regs  = VEC[i][19:4];
            #2 chk($sformatf("R6 R8 query vector %0d", i), int'(qry_short), int'(VEC[i][3:0]));
        end
        @(negedge clk);
        qry_valid = 0;

        // R4: free with and without enable
        op(0, 0, 0, 1, 1, 3);
        chk_used("R4 free r3", 3, 2, 0, 0);
        op(0, 0, 0, 1, 0, 3);
        chk_used("R4 free no enable", 3, 2, 0, 0);
        chk("R4 err clear", int'(free_err), 0);

        // R5: underflow clamps file 2, file 0 still decrements
        op(0, 0, 0, 1, 1, 3);
        chk_used("R5 underflow", 2, 2, 0, 0);
        chk("R5 err set", int'(free_err), 1);

        // R9: allocate r1 and free r2 in the same cycle
        op(1, 1, 1, 1, 1, 2);
        chk_used("R9 same cycle net", 1, 1, 0, 0);
        chk("R5 err sticky", int'(free_err), 1);

        // R10: remap r1 to file 2 cost 3
        set_map(1, 2, 3);
        op(1, 1, 1, 0, 0, 0);
        chk_used("R10 remap alloc", 4, 1, 3, 0);

        // R7: file 1 becomes unbounded
        set_cap(1, 0);
        @(negedge clk);
        qry_valid = 4'hF; qry_regs = 16'h2222;
        #2 chk("R7 unbounded file1 mask", int'(qry_short), 1);
        qry_valid = 0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule